// File: doc/BRIEF.md
# Cascaded Watchdog Timer with Early Warning

This block watches host software and resets the system when the host stops servicing it. A free-running prescaler divides the bus clock by 16 and drives a first down-counter. That counter acts as a square-wave divider. Each of its periods steps a second down-counter, so the two counters form one 32-bit timeout chain. Software keeps the system alive by rewriting the second counter before the chain runs out. One first-counter period before expiry, a sticky interrupt request warns the host so it can still recover.

On expiry, a reset pulse is driven in two forms: active-high and active-low. A third counter sets the width of the pulse. Its tick can be half the bus clock or the bus clock divided by 16. When the pulse ends, the chain restarts from its load values. All control is through byte-wide register writes and read strobes. All dividers are clock enables inside the one bus clock domain.

Top module: `wdog_cascade`

## Requirements
- R1: After reset the timer is disarmed, `irq` is 0, `rst_pulse` is 0, `rst_n_out` is 1 and the fast reset-width clock is selected.
- R2: Load registers are written a byte at a time: address 0/1 = first counter low/high byte, 2/3 = second counter low/high, 4/5 = third counter low/high. A stored load value of 0 stands for 65536; the valid range is 2 to 65536.
- R3: While armed, the prescaler produces one tick every 16 bus cycles. The first counter completes a period every N0 ticks. Each period decrements the second counter. The chain expires on the edge N0·N1·16 cycles after arming.
- R4: A write of any value to address 6 arms the timer and restarts everything from the load registers. This holds even when the timer is already armed: the prescaler, both chain counters and `irq` are all cleared or reloaded.
- R5: `irq` rises on the edge N0·(N1−1)·16 cycles after arming, one first-counter period before expiry, and stays high until the second counter is reloaded.
- R6: A write to address 3 stores the high byte and reloads the second counter from the full new value. This write is the refresh. It clears `irq` on the next cycle and leaves the prescaler and first counter running undisturbed. A refresh on the same edge as expiry wins.
- R7: On expiry `rst_pulse` goes to 1 and `rst_n_out` goes to 0 on the same edge, and `irq` is cleared.
- R8: The pulse lasts N2 width ticks: N2·2 cycles with the fast clock, N2·16 with the slow one. After the pulse the chain restarts, so a silent host sees the next expiry N0·N1·16 cycles after the pulse ends.
- R9: A write to address 7 selects the slow width clock; a read of address 7 restores the fast one.
- R10: A read of address 6 disarms the timer. This ends any active pulse on the next edge, clears `irq`, and keeps both outputs inactive until the timer is armed again.
- R11: A third-counter load of 0 gives a pulse of 65536 width ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| irq | output | 1 | Sticky early-warning interrupt request |
| rst_pulse | output | 1 | Active-high system reset pulse |
| rst_n_out | output | 1 | Active-low system reset |

## Verification
The bench checks exact edge counts for warning, expiry and pulse end. An off-by-one in the prescaler, in the first counter's terminal count or in the third counter's reload would move one of these by whole ticks.

A refresh is issued mid-period to show that only the second counter restarts. A design that also reloaded the prescaler or first counter would expire several cycles late.

Further checks cover:
- disarming in the middle of a pulse, which would leave reset stuck if disarm did not clear it;
- re-arming while the warning is up;
- the slow width clock and its restoration;
- the zero-means-65536 encoding, which a 16-bit counter would turn into an instant or a single-tick pulse.

// File: rtl/wdog_cascade.sv
module wdog_cascade #(
  parameter int PRE_DIV  = 16,
  parameter int FAST_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic       irq,
  output logic       rst_pulse,
  output logic       rst_n_out
);

  localparam int LW = 16;
  localparam int EW = LW + 1;
  localparam int PW = $clog2(PRE_DIV);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [PW-1:0] FAST_LAST = PW'(FAST_DIV - 1);

  localparam logic [2:0] A_L0LO = 3'd0, A_L0HI = 3'd1, A_L1LO = 3'd2, A_L1HI = 3'd3;
  localparam logic [2:0] A_L2LO = 3'd4, A_L2HI = 3'd5, A_ARM  = 3'd6, A_RATE = 3'd7;

  function automatic logic [EW-1:0] span(input logic [LW-1:0] v);
    return (v == '0) ? {1'b1, {LW{1'b0}}} : {1'b0, v};
  endfunction

  logic [LW-1:0] ld0, ld1, ld2;
  logic [EW-1:0] c0, c1, c2;
  logic [PW-1:0] pcnt, fcnt;
  logic armed, in_rst, slow, warn;

  wire arm_w   = wr_en && addr == A_ARM;
  wire disarm  = rd_en && addr == A_ARM;
  wire refresh = wr_en && addr == A_L1HI;
  wire restart = arm_w || disarm;
  wire [LW-1:0] ld1_new = {wdata, ld1[7:0]};

  wire tick0     = armed && !in_rst && pcnt == PRE_LAST;
  wire c0_done   = tick0 && c0 == EW'(1);
  wire expire    = c0_done && c1 == EW'(1) && !refresh && !restart;
  wire [PW-1:0] w_last = slow ? PRE_LAST : FAST_LAST;
  wire tick2     = in_rst && fcnt >= w_last;
  wire pulse_end = tick2 && c2 == EW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld0 <= '0;
      ld1 <= '0;
      ld2 <= '0;
      slow <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_L0LO: ld0[7:0]  <= wdata;
          A_L0HI: ld0[15:8] <= wdata;
          A_L1LO: ld1[7:0]  <= wdata;
          A_L1HI: ld1[15:8] <= wdata;
          A_L2LO: ld2[7:0]  <= wdata;
          A_L2HI: ld2[15:8] <= wdata;
          A_RATE: slow <= 1'b1;
          default: ;
        endcase
      end
      if (rd_en && addr == A_RATE) slow <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      in_rst <= 1'b0;
    end else begin
      if (disarm) armed <= 1'b0;
      else if (arm_w) armed <= 1'b1;
      if (restart || pulse_end) in_rst <= 1'b0;
      else if (expire) in_rst <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      c0   <= '0;
    end else begin
      if (restart || !armed || in_rst || pcnt == PRE_LAST) pcnt <= '0;
      else pcnt <= pcnt + 1'b1;
      if (restart || !armed || pulse_end) c0 <= span(ld0);
      else if (tick0) c0 <= (c0 == EW'(1)) ? span(ld0) : c0 - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1   <= '0;
      warn <= 1'b0;
    end else begin
      if (restart || !armed || pulse_end) c1 <= span(ld1);
      else if (refresh) c1 <= span(ld1_new);
      else if (c0_done) c1 <= (c1 == EW'(1)) ? span(ld1) : c1 - 1'b1;
      if (restart || !armed || refresh || expire || pulse_end) warn <= 1'b0;
      else if (c0_done && c1 == EW'(2)) warn <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt <= '0;
      c2   <= '0;
    end else begin
      if (!in_rst || tick2) fcnt <= '0;
      else fcnt <= fcnt + 1'b1;
      if (expire) c2 <= span(ld2);
      else if (tick2 && c2 != EW'(1)) c2 <= c2 - 1'b1;
    end
  end

  assign irq       = warn;
  assign rst_pulse = in_rst;
  assign rst_n_out = !in_rst;

  AST_IDLE_QUIET:    assert property (@(posedge clk) disable iff (!rst_n) !armed |-> (!irq && !rst_pulse));              // R10
  AST_DISARM_ENDS:   assert property (@(posedge clk) disable iff (!rst_n) disarm |=> (!rst_pulse && !armed));             // R10
  AST_REFRESH_CLR:   assert property (@(posedge clk) disable iff (!rst_n) (refresh && !restart) |=> !irq);               // R6
  AST_PULSE_NO_WARN: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_pulse) |-> (!irq && $past(armed)));  // R7
  AST_CHAIN_LIVE:    assert property (@(posedge clk) disable iff (!rst_n) armed |-> (c1 != '0 && c0 != '0));              // R3
  AST_WIDTH_LIVE:    assert property (@(posedge clk) disable iff (!rst_n) in_rst |-> c2 != '0);                          // R8

endmodule

// File: tb/test_wdog_cascade.sv
module test_wdog_cascade;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic irq, rst_pulse, rst_n_out;

  int n_chk = 0, n_fail = 0, t = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdog_cascade i_wdog_cascade (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .irq(irq), .rst_pulse(rst_pulse), .rst_n_out(rst_n_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at t=%0d: actual %0d expected %0d", req, what, t, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); t++;
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk); t++;
    rd_en = 1'b0;
  endtask

  task automatic goto(input int target);
    while (t < target) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic setup(input int n0, input int n1, input int n2);
    do_read(3'd6);
    do_write(3'd0, n0[7:0]);  do_write(3'd1, n0[15:8]);
    do_write(3'd2, n1[7:0]);  do_write(3'd3, n1[15:8]);
    do_write(3'd4, n2[7:0]);  do_write(3'd5, n2[15:8]);
  endtask

  task automatic arm();
    do_write(3'd6, 8'h5a);
    t = 0;
  endtask

  task automatic t_reset();
    check("R1", "irq", irq, 0);
    check("R1", "rst_pulse", rst_pulse, 0);
    check("R1", "rst_n_out", rst_n_out, 1);
  endtask

  task automatic t_basic();
    setup(2, 3, 3);
    arm();
    goto(63);  check("R5", "irq before warn", irq, 0);
    goto(64);  check("R5", "irq at warn", irq, 1);
    goto(95);  check("R3", "pulse before expiry", rst_pulse, 0);
    check("R5", "irq sticky", irq, 1);
    goto(96);  check("R7", "rst_pulse at expiry", rst_pulse, 1);
    check("R7", "rst_n_out at expiry", rst_n_out, 0);
    check("R7", "irq cleared", irq, 0);
    goto(101); check("R8", "pulse last fast cycle", rst_pulse, 1);
    goto(102); check("R8", "pulse ended", rst_pulse, 0);
    check("R8", "rst_n_out released", rst_n_out, 1);
    goto(165); check("R8", "restart irq before", irq, 0);
    goto(166); check("R8", "restart irq", irq, 1);
    goto(197); check("R8", "restart pulse before", rst_pulse, 0);
    goto(198); check("R8", "restart expiry", rst_pulse, 1);
    do_read(3'd6);
  endtask

  task automatic t_refresh();
    setup(2, 3, 3);
    arm();
    goto(49);  do_write(3'd3, 8'h00);
    goto(95);  check("R6", "irq after refresh", irq, 0);
    goto(96);  check("R6", "irq moves with refresh", irq, 1);
    goto(99);  do_write(3'd3, 8'h00);
    check("R6", "refresh clears irq", irq, 0);
    goto(191); check("R6", "no early expiry", rst_pulse, 0);
    goto(192); check("R6", "first counter not reloaded", rst_pulse, 1);
    do_read(3'd6);
  endtask

  task automatic t_slow();
    setup(2, 3, 3);
    do_write(3'd7, 8'h00);
    arm();
    goto(96);  check("R9", "slow pulse start", rst_pulse, 1);
    goto(143); check("R9", "slow pulse last", rst_pulse, 1);
    goto(144); check("R9", "slow pulse end", rst_pulse, 0);
    do_read(3'd6);
    do_read(3'd7);
    arm();
    goto(101); check("R9", "fast restored last", rst_pulse, 1);
    goto(102); check("R9", "fast restored end", rst_pulse, 0);
    do_read(3'd6);
  endtask

  task automatic t_disarm();
    setup(2, 3, 3);
    arm();
    goto(98);  check("R10", "in pulse", rst_pulse, 1);
    do_read(3'd6);
    check("R10", "pulse ended by disarm", rst_pulse, 0);
    check("R10", "rst_n_out released", rst_n_out, 1);
    goto(400); check("R10", "stays quiet", rst_pulse, 0);
    check("R10", "no warn while disarmed", irq, 0);
  endtask

  task automatic t_rearm();
    setup(2, 3, 3);
    arm();
    goto(70);  check("R4", "warn up", irq, 1);
    arm();
    check("R4", "rearm clears irq", irq, 0);
    goto(95);  check("R4", "rearm delays expiry", rst_pulse, 0);
    goto(96);  check("R4", "expiry from rearm", rst_pulse, 1);
    do_read(3'd6);
  endtask

  task automatic t_zero();
    setup(2, 2, 0);
    arm();
    goto(32);  check("R5", "warn with N1=2", irq, 1);
    goto(64);  check("R3", "expiry N1=2", rst_pulse, 1);
    goto(64 + 131071); check("R11", "zero width pulse still high", rst_pulse, 1);
    goto(64 + 131072); check("R2", "zero means 65536", rst_pulse, 0);
    do_read(3'd6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_refresh();
    t_slow();
    t_disarm();
    t_rearm();
    t_zero();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual t=%0d expected completion", t);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule